// File: doc/BRIEF.md
# Microcoded 16-bit ALU with Carry

This block is the arithmetic and logic stage of a small microcode engine. Two 16-bit operands, an operation code, a mask immediate, a shift immediate and a carry-write enable go in. A 16-bit result comes out within the same cycle. A single carry flag is held in a register, and that flag is the only state in the block. The register file, operand fetch, memory operands and instruction decode sit outside it.

Addition and subtraction each come in four forms. The operation code chooses whether the stored carry is used as carry-in. The carry-write enable chooses whether the carry-out is captured. Beside the arithmetic there are bitwise logic operations, shifts and rotates by a register amount, and two merge operations. The first merge rotates one operand and inserts a masked field of it into the other. The second is a funnel right shift across both operands, inserted the same way. A register copy is an OR with a zero second operand.

Top module: `mc_alu16`

## Requirements
- R1: With op 0 the result is (a + b) mod 2^16. With op 1 the result is (a + b + c) mod 2^16, where c is the stored carry flag.
- R2: With op 2 the result is (a + ~b + 1) mod 2^16. With op 3 the result is (a + ~b + c) mod 2^16.
- R3: When cwe is 1 and op is 0 to 3, the carry flag takes bit 16 of the 17-bit sum on the next rising clock edge. For subtraction this bit is 1 exactly when no borrow occurs.
- R4: The carry flag clears while rst_n is low. It keeps its value on every edge where cwe is 0 or op is 4 or higher.
- R5: Op 4 gives a OR b, op 5 gives a AND b, op 6 gives a XOR b, and op 7 gives a AND NOT b.
- R6: Op 8 shifts a left logically by b[3:0]. Op 9 shifts a right logically by b[3:0]. Op 10 shifts a right arithmetically by b[3:0], filling with copies of a[15].
- R7: Op 11 rotates a left by b[3:0], and op 12 rotates a right by b[3:0].
- R8: Op 13 gives (rotl(a, S) AND m) OR (b AND NOT m). Here m has its low M+1 bits set, M is msk_i and S is sft_i.
- R9: Op 14 gives (low 16 bits of ({a,b} >> S)) AND m, OR (b AND NOT m). In {a,b}, a is the upper half, and m is as in R8.
- R10: Op 4 with b = 0 returns a unchanged, which serves as a register copy.
- R11: Op 15 is unused and gives a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand; its low 4 bits are the shift amount |
| op_i | input | 4 | Operation code, 0 to 15 |
| msk_i | input | 4 | Mask immediate M (field width minus one) |
| sft_i | input | 4 | Shift immediate S for the merge operations |
| cwe_i | input | 1 | Carry-write enable for the arithmetic operations |
| res_o | output | 16 | Result |
| carry_o | output | 1 | Stored carry flag |

## Verification
The bench chains a 0xFFFF + 1 carry into a following add-with-carry. It also uses a borrowing subtract to clear the flag before a subtract-with-carry. A design that inverted the borrow sense, or took carry-in from the wrong source, would give results off by one. Carry-hold cases set cwe on logic operations and clear it on arithmetic ones, so a flag that updates too often shows up as a wrong carry. Shifts by 0 and by 15 on negative values catch a missing sign fill or an amount taken from too many bits. Merges with M = 15 and M = 0 and a nonzero S catch an off-by-one mask, a wrong rotate direction, and a funnel that takes its bits from the wrong half.

// File: rtl/mc_alu_pkg.sv
package mc_alu_pkg;
  localparam int unsigned DW  = 16;
  localparam int unsigned OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_OR   = 4'd4,
    OP_AND  = 4'd5,
    OP_XOR  = 4'd6,
    OP_BCLR = 4'd7,
    OP_SHL  = 4'd8,
    OP_SHR  = 4'd9,
    OP_SAR  = 4'd10,
    OP_ROL  = 4'd11,
    OP_ROR  = 4'd12,
    OP_MRG  = 4'd13,
    OP_FNL  = 4'd14,
    OP_NONE = 4'd15
  } alu_op_e;
endpackage

// File: rtl/mc_alu_addsub.sv
module mc_alu_addsub #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    full   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
    sum_o  = full[W-1:0];
    cout_o = full[W];
  end
endmodule

// File: rtl/mc_alu_shift.sv
module mc_alu_shift #(
  parameter int unsigned W = 16,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  shl_o,
  output logic [W-1:0]  shr_o,
  output logic [W-1:0]  sar_o,
  output logic [W-1:0]  rol_o,
  output logic [W-1:0]  ror_o
);
  logic [2*W-1:0] dbl_l;
  logic [2*W-1:0] dbl_r;

  always_comb begin
    shl_o = a_i << amt_i;
    shr_o = a_i >> amt_i;
    sar_o = W'($signed(a_i) >>> amt_i);
    dbl_l = {a_i, a_i} << amt_i;
    dbl_r = {a_i, a_i} >> amt_i;
    rol_o = dbl_l[2*W-1:W];
    ror_o = dbl_r[W-1:0];
  end
endmodule

// File: rtl/mc_alu_merge.sv
module mc_alu_merge #(
  parameter int unsigned W = 16,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [SW-1:0] msk_i,
  input  logic [SW-1:0] sft_i,
  output logic [W-1:0]  mrg_o,
  output logic [W-1:0]  fnl_o
);
  logic [W-1:0]   fmask;
  logic [2*W-1:0] rot_dbl;
  logic [2*W-1:0] fun_dbl;
  logic [W-1:0]   rot_val;
  logic [W-1:0]   fun_val;

  // Field mask: bit i set when i <= M
  for (genvar i = 0; i < W; i++) begin : g_mask
    assign fmask[i] = (SW'(i) <= msk_i);
  end

  always_comb begin
    rot_dbl = {a_i, a_i} << sft_i;
    rot_val = rot_dbl[2*W-1:W];
    fun_dbl = {a_i, b_i} >> sft_i;
    fun_val = fun_dbl[W-1:0];
    mrg_o   = (rot_val & fmask) | (b_i & ~fmask);
    fnl_o   = (fun_val & fmask) | (b_i & ~fmask);
  end
endmodule

// File: rtl/mc_alu16.sv
module mc_alu16
  import mc_alu_pkg::*;
#(
  parameter int unsigned W = DW,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [OPW-1:0] op_i,
  input  logic [SW-1:0]  msk_i,
  input  logic [SW-1:0]  sft_i,
  input  logic           cwe_i,
  output logic [W-1:0]   res_o,
  output logic           carry_o
);
  alu_op_e      op;
  logic         carry_q, carry_d, carry_en;
  logic         is_arith, is_sub, cin;
  logic [W-1:0] sum, shl, shr, sar, rol, ror, mrg, fnl;
  logic         cout;

  assign op       = alu_op_e'(op_i);
  assign is_arith = (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB) || (op == OP_SUBC);
  assign is_sub   = (op == OP_SUB) || (op == OP_SUBC);

  always_comb begin
    unique case (op)
      OP_ADD:  cin = 1'b0;
      OP_SUB:  cin = 1'b1;
      default: cin = carry_q;
    endcase
  end

  mc_alu_addsub #(.W(W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(is_sub), .cin_i(cin),
    .sum_o(sum), .cout_o(cout)
  );

  mc_alu_shift #(.W(W)) u_shift (
    .a_i(a_i), .amt_i(b_i[SW-1:0]),
    .shl_o(shl), .shr_o(shr), .sar_o(sar), .rol_o(rol), .ror_o(ror)
  );

  mc_alu_merge #(.W(W)) u_merge (
    .a_i(a_i), .b_i(b_i), .msk_i(msk_i), .sft_i(sft_i),
    .mrg_o(mrg), .fnl_o(fnl)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: res_o = sum;
      OP_OR:   res_o = a_i | b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_BCLR: res_o = a_i & ~b_i;
      OP_SHL:  res_o = shl;
      OP_SHR:  res_o = shr;
      OP_SAR:  res_o = sar;
      OP_ROL:  res_o = rol;
      OP_ROR:  res_o = ror;
      OP_MRG:  res_o = mrg;
      OP_FNL:  res_o = fnl;
      default: res_o = '0;
    endcase
  end

  // Carry flag: next-state and register processes
  assign carry_en = cwe_i && is_arith;
  assign carry_d  = cout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        carry_q <= 1'b0;
    else if (carry_en) carry_q <= carry_d;
  end

  assign carry_o = carry_q;

  // Assertions
  logic [W-1:0] keep_m;
  assign keep_m = {W{1'b1}} << (int'(msk_i) + 1);

  always @(posedge clk) begin
    if (!rst_n) assert_carry_reset_R4: assert (carry_q == 1'b0);
  end

  assert_add_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADD && cwe_i) |=> (carry_q == ($past(res_o) < $past(a_i))));

  assert_sub_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SUB && cwe_i) |=> (carry_q == ($past(a_i) >= $past(b_i))));

  assert_carry_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cwe_i && is_arith) |=> $stable(carry_q));

  assert_rot_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ROL || op == OP_ROR) |-> ($countones(res_o) == $countones(a_i)));

  assert_merge_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MRG || op == OP_FNL) |-> (((res_o ^ b_i) & keep_m) == '0));

  assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE) |-> (res_o == '0));
endmodule

// File: tb/mc_alu16_bench.sv
module mc_alu16_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] a, b;
  logic [3:0]  op, msk, sft;
  logic        cwe;
  logic [15:0] res;
  logic        carry;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_alu16 u_mc_alu16 (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .op_i(op),
    .msk_i(msk), .sft_i(sft), .cwe_i(cwe), .res_o(res), .carry_o(carry)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply inputs away from the edge, compare combinational result
  task automatic apply(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y,
                       input logic [3:0] m, input logic [3:0] s, input logic w);
    @(negedge clk);
    op = o; a = x; b = y; msk = m; sft = s; cwe = w;
    #1;
  endtask

  task automatic settle_edge();
    @(posedge clk); #1;
  endtask

  function automatic logic [15:0] fmask(input logic [3:0] m);
    logic [15:0] r = '0;
    for (int i = 0; i <= int'(m); i++) r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic [15:0] rotl(input logic [15:0] x, input int s);
    logic [15:0] r = x;
    for (int i = 0; i < s; i++) r = {r[14:0], r[15]};
    return r;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; op = 4'd0; a = '0; b = '0; msk = '0; sft = '0; cwe = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R4 reset carry", {15'd0, carry}, 16'd0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_arith();
    apply(4'd0, 16'h1234, 16'h4321, 0, 0, 0);
    chk("R1 add", res, 16'h5555);
    apply(4'd0, 16'hFFFF, 16'h0001, 0, 0, 1);
    chk("R1 add wrap", res, 16'h0000);
    settle_edge();
    chk("R3 add carry out", {15'd0, carry}, 16'd1);
    apply(4'd1, 16'h0000, 16'h0000, 0, 0, 0);
    chk("R1 addc uses carry", res, 16'h0001);
    settle_edge();
    chk("R4 carry held cwe=0", {15'd0, carry}, 16'd1);
    apply(4'd2, 16'h0001, 16'h0002, 0, 0, 1);
    chk("R2 sub borrow", res, 16'hFFFF);
    settle_edge();
    chk("R3 sub borrow carry", {15'd0, carry}, 16'd0);
    apply(4'd3, 16'h0005, 16'h0003, 0, 0, 1);
    chk("R2 subc carry0", res, 16'h0001);
    settle_edge();
    chk("R3 subc no borrow", {15'd0, carry}, 16'd1);
    apply(4'd3, 16'h0005, 16'h0003, 0, 0, 0);
    chk("R2 subc carry1", res, 16'h0002);
    apply(4'd2, 16'h0007, 16'h0007, 0, 0, 0);
    chk("R2 sub equal", res, 16'h0000);
  endtask

  task automatic t_carry_hold();
    // carry is 1 here; logic op with cwe=1 must not touch it
    apply(4'd6, 16'h0000, 16'h0000, 0, 0, 1);
    settle_edge();
    chk("R4 carry held logic op", {15'd0, carry}, 16'd1);
    apply(4'd2, 16'h0000, 16'h0001, 0, 0, 0);
    settle_edge();
    chk("R4 carry held sub cwe=0", {15'd0, carry}, 16'd1);
  endtask

  task automatic t_logic();
    apply(4'd4, 16'hF0F0, 16'h0FF0, 0, 0, 0); chk("R5 or",   res, 16'hFFF0);
    apply(4'd5, 16'hF0F0, 16'h0FF0, 0, 0, 0); chk("R5 and",  res, 16'h00F0);
    apply(4'd6, 16'hF0F0, 16'h0FF0, 0, 0, 0); chk("R5 xor",  res, 16'hFF00);
    apply(4'd7, 16'hF0F0, 16'h0FF0, 0, 0, 0); chk("R5 bclr", res, 16'hF000);
    apply(4'd4, 16'hBEEF, 16'h0000, 0, 0, 0); chk("R10 copy", res, 16'hBEEF);
    apply(4'd15, 16'hFFFF, 16'hFFFF, 4'hF, 4'hF, 0); chk("R11 unused", res, 16'h0000);
  endtask

  task automatic t_shift();
    apply(4'd8,  16'h8001, 16'h0003, 0, 0, 0); chk("R6 shl 3", res, 16'h0008);
    apply(4'd9,  16'h8001, 16'hFFF0, 0, 0, 0); chk("R6 shr 0 uses low bits", res, 16'h8001);
    apply(4'd9,  16'h8000, 16'h000F, 0, 0, 0); chk("R6 shr 15", res, 16'h0001);
    apply(4'd10, 16'h8000, 16'h000F, 0, 0, 0); chk("R6 sar 15", res, 16'hFFFF);
    apply(4'd10, 16'h4000, 16'h0002, 0, 0, 0); chk("R6 sar pos", res, 16'h1000);
    apply(4'd11, 16'h8001, 16'h0001, 0, 0, 0); chk("R7 rol 1", res, 16'h0003);
    apply(4'd12, 16'h8001, 16'h0001, 0, 0, 0); chk("R7 ror 1", res, 16'hC000);
    apply(4'd11, 16'h1234, 16'h0004, 0, 0, 0); chk("R7 rol 4", res, 16'h2341);
  endtask

  task automatic t_merge();
    logic [15:0] exp;
    apply(4'd13, 16'h1234, 16'hFFFF, 4'd15, 4'd4, 0);
    chk("R8 full mask", res, 16'h2341);
    apply(4'd13, 16'h0001, 16'hAAAA, 4'd0, 4'd0, 0);
    chk("R8 one bit", res, 16'hAAAB);
    exp = (rotl(16'h00F3, 8) & fmask(4'd7)) | (16'h5A5A & ~fmask(4'd7));
    apply(4'd13, 16'h00F3, 16'h5A5A, 4'd7, 4'd8, 0);
    chk("R8 byte field", res, exp);
    apply(4'd14, 16'h00AB, 16'hCD00, 4'd15, 4'd8, 0);
    chk("R9 funnel 8", res, 16'hABCD);
    apply(4'd14, 16'h0001, 16'hFFF0, 4'd3, 4'd4, 0);
    chk("R9 funnel field", res, 16'hFFFF);
    apply(4'd14, 16'h1234, 16'h5678, 4'd15, 4'd0, 0);
    chk("R9 funnel 0", res, 16'h5678);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_carry_hold();
    t_logic();
    t_shift();
    t_merge();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule